// File: doc/BRIEF.md
# Call, Return and Software Interrupt Sequencer

This block handles control transfers that go through a return stack in a small 16-bit-address core. The decoder presents one operation code per cycle, together with the address of the following instruction, two immediates, the extension byte and its enable flag, the X pointer and the live 4-bit flag set. For calls the block works out the destination and saves the following address on an internal stack. For returns it takes the newest entry off the stack and redirects the program counter. Every new program counter value comes out as a one-cycle load pulse in the cycle after the operation is taken.

There are four calls. The zero-page call goes to a fixed low address. The relative call adds a signed offset that can be widened by the extension byte. The memory-offset call adds a nibble fetched from a small data region. The software interrupt goes to a vector inside a fixed page and also saves the flags. There are four returns. The plain return resumes at the saved address. The skip return resumes one past it. The data return resumes and also stores a byte through X as two nibble writes. The flag return restores the saved flags as well as the address. The stack depth is a parameter. A push onto a full stack or a pop from an empty one is refused, and an error pulse reports it.

Top module: `callret_seq`

## Requirements
- R1: After reset the outputs pcLoad, flagsLoad, memWe, busy, ovfErr and unfErr are low and the stack is empty.
- R2: opCode 4'h1 (zero-page call) loads pcOut = {8'h00, imm8} and pushes nextPc.
- R3: opCode 4'h2 (relative call) loads nextPc plus an offset. When extFlag is 0 the offset is imm8 sign-extended. When extFlag is 1 the offset is {extReg, imm8} read as a 16-bit signed value. nextPc is pushed.
- R4: memRdAddr always equals imm6. opCode 4'h3 (memory-offset call) loads nextPc + memRdData, with memRdData sampled in the operation's cycle and zero-extended. nextPc is pushed.
- R5: opCode 4'h4 (software interrupt) loads 16'h0100 + imm6 and pushes both nextPc and flagsIn.
- R6: opCode 4'h5 (plain return) pops an entry and loads its address into pcOut. flagsLoad stays low.
- R7: opCode 4'h6 (skip return) pops an entry and loads its address plus 1.
- R8: opCode 4'h7 (data return) loads the popped address with flagsLoad low. In that same cycle memWe writes imm8[3:0] to address xReg. In the next cycle it writes imm8[7:4] to xReg+1. busy is high in both cycles.
- R9: opCode 4'h8 (flag return) pops an entry, loads its address, and pulses flagsLoad with flagsOut equal to the saved flags.
- R10: A call or interrupt on a full stack pulses ovfErr for one cycle, produces no pcLoad and leaves the stack contents and depth unchanged.
- R11: A return of any kind on an empty stack pulses unfErr for one cycle and produces no pcLoad, no flagsLoad and no memory write.
- R12: Any opCode presented while busy is high is ignored. It produces no load and does not change the stack.
- R13: Entries come off the stack in reverse order of push, for up to DEPTH entries.
- R14: Every result (pcLoad, flagsLoad, ovfErr, unfErr, the first nibble write) appears in the cycle right after the clock edge that takes the operation. An opCode of 4'h0 or above 4'h8 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 4 | Operation code; 0 means none |
| nextPc | input | 16 | Address of the instruction after the current one |
| imm8 | input | 8 | Byte immediate: call target, offset or data byte |
| imm6 | input | 6 | Vector index and data address for the memory-offset call |
| extReg | input | 8 | High byte for the widened relative offset |
| extFlag | input | 1 | Selects the widened relative offset |
| xReg | input | 16 | Data pointer for the data return |
| flagsIn | input | 4 | Current flags |
| memRdAddr | output | 6 | Read address toward data memory |
| memRdData | input | 4 | Nibble read from memRdAddr in the same cycle |
| pcLoad | output | 1 | Program counter load pulse |
| pcOut | output | 16 | New program counter value |
| flagsLoad | output | 1 | Flag restore pulse |
| flagsOut | output | 4 | Flags to restore |
| memWe | output | 1 | Data memory nibble write enable |
| memWrAddr | output | 16 | Write address |
| memWrData | output | 4 | Write nibble |
| busy | output | 1 | Data write sequence in progress |
| ovfErr | output | 1 | Push refused because the stack was full |
| unfErr | output | 1 | Pop refused because the stack was empty |

## Verification
The data return is the one operation that does two things in the same cycle: it loads the program counter and it issues the first nibble write. On top of that, a further operation can arrive while the second nibble is still being written. The bench issues a data return and checks, in the same sample, that the load pulse fires and that the low nibble goes to X. It then presents a plain return during the busy window and checks that the high nibble goes to X+1 with no load pulse. Finally it pops once more and expects an underflow, which shows that the ignored return left the stack untouched.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [3:0] {
    OP_NONE      = 4'h0,
    OP_ABS_CALL  = 4'h1,
    OP_REL_CALL  = 4'h2,
    OP_MEM_CALL  = 4'h3,
    OP_SW_INT    = 4'h4,
    OP_RET       = 4'h5,
    OP_RET_SKIP  = 4'h6,
    OP_RET_DATA  = 4'h7,
    OP_RET_FLAGS = 4'h8
  } opKind_e;

  typedef enum logic [2:0] {
    TGT_ABS,
    TGT_REL,
    TGT_MEM,
    TGT_VEC,
    TGT_POP,
    TGT_POP_INC
  } tgtSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     push;
    logic     pop;
    tgtSel_e  tgtSel;
    logic     loadPc;
    logic     loadFlags;
    logic     captureWr;
    logic     wrLo;
    logic     wrHi;
    logic     ovf;
    logic     unf;
  } seqStrobe_t;

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opCode,
  input  logic       stackFull,
  input  logic       stackEmpty,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_e state, stateNext;
  opKind_e   op;

  assign op   = opKind_e'(opCode);
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_WR_LO: begin
        strobe.wrLo = 1'b1;
        stateNext   = ST_WR_HI;
      end
      ST_WR_HI: begin
        strobe.wrHi = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: begin
        case (op)
          OP_ABS_CALL, OP_REL_CALL, OP_MEM_CALL, OP_SW_INT: begin
            if (stackFull) begin
              strobe.ovf = 1'b1;
            end else begin
              strobe.push   = 1'b1;
              strobe.loadPc = 1'b1;
              case (op)
                OP_ABS_CALL: strobe.tgtSel = TGT_ABS;
                OP_REL_CALL: strobe.tgtSel = TGT_REL;
                OP_MEM_CALL: strobe.tgtSel = TGT_MEM;
                default:     strobe.tgtSel = TGT_VEC;
              endcase
            end
          end
          OP_RET, OP_RET_SKIP, OP_RET_DATA, OP_RET_FLAGS: begin
            if (stackEmpty) begin
              strobe.unf = 1'b1;
            end else begin
              strobe.pop    = 1'b1;
              strobe.loadPc = 1'b1;
              strobe.tgtSel = (op == OP_RET_SKIP) ? TGT_POP_INC : TGT_POP;
              if (op == OP_RET_FLAGS) strobe.loadFlags = 1'b1;
              if (op == OP_RET_DATA) begin
                strobe.captureWr = 1'b1;
                stateNext        = ST_WR_LO;
              end
            end
          end
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/callret_dp.sv
module callret_dp
  import callret_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              FLAG_W   = 4,
  parameter int              DEPTH    = 8,
  parameter int              NIB_W    = 4,
  parameter int              MADDR_W  = 6,
  parameter logic [PC_W-1:0] VEC_BASE = 'h0100
)(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [PC_W-1:0]    nextPc,
  input  logic [2*NIB_W-1:0] imm8,
  input  logic [MADDR_W-1:0] imm6,
  input  logic [PC_W/2-1:0]  extReg,
  input  logic               extFlag,
  input  logic [PC_W-1:0]    xReg,
  input  logic [FLAG_W-1:0]  flagsIn,
  input  logic [NIB_W-1:0]   memRdData,
  output logic [MADDR_W-1:0] memRdAddr,
  output logic               stackFull,
  output logic               stackEmpty,
  output logic               pcLoad,
  output logic [PC_W-1:0]    pcOut,
  output logic               flagsLoad,
  output logic [FLAG_W-1:0]  flagsOut,
  output logic               memWe,
  output logic [PC_W-1:0]    memWrAddr,
  output logic [NIB_W-1:0]   memWrData,
  output logic               ovfErr,
  output logic               unfErr
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int BYTE_W = 2 * NIB_W;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [FLAG_W-1:0] flags;
  } entry_t;

  entry_t            stackMem [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [IDX_W-1:0]  pushIdx, topIdx;
  entry_t            topEntry;
  logic [PC_W-1:0]   relOff, target;
  logic [PC_W-1:0]   wrBase;
  logic [BYTE_W-1:0] wrByte;

  assign memRdAddr  = imm6;
  assign stackFull  = (sp == SP_W'(DEPTH));
  assign stackEmpty = (sp == '0);
  assign pushIdx    = IDX_W'(sp);
  assign topIdx     = IDX_W'(sp - 1'b1);
  assign topEntry   = stackMem[topIdx];

  // target selection
  always_comb begin
    relOff = extFlag ? PC_W'({extReg, imm8}) : PC_W'($signed(imm8));
    unique case (strobe.tgtSel)
      TGT_ABS:     target = PC_W'(imm8);
      TGT_REL:     target = nextPc + relOff;
      TGT_MEM:     target = nextPc + PC_W'(memRdData);
      TGT_VEC:     target = VEC_BASE + PC_W'(imm6);
      TGT_POP_INC: target = topEntry.pc + 1'b1;
      default:     target = topEntry.pc;
    endcase
  end

  // return stack
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= '0;
    end else if (strobe.push) begin
      sp <= sp + 1'b1;
    end else if (strobe.pop) begin
      sp <= sp - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strobe.push && pushIdx == IDX_W'(i))
          stackMem[i] <= '{pc: nextPc, flags: flagsIn};
      end
    end
  endgenerate

  // registered results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcLoad    <= 1'b0;
      pcOut     <= '0;
      flagsLoad <= 1'b0;
      flagsOut  <= '0;
      ovfErr    <= 1'b0;
      unfErr    <= 1'b0;
      wrBase    <= '0;
      wrByte    <= '0;
    end else begin
      pcLoad    <= strobe.loadPc;
      flagsLoad <= strobe.loadFlags;
      ovfErr    <= strobe.ovf;
      unfErr    <= strobe.unf;
      if (strobe.loadPc)    pcOut    <= target;
      if (strobe.loadFlags) flagsOut <= topEntry.flags;
      if (strobe.captureWr) begin
        wrBase <= xReg;
        wrByte <= imm8;
      end
    end
  end

  // nibble write port
  assign memWe     = strobe.wrLo | strobe.wrHi;
  assign memWrAddr = strobe.wrHi ? wrBase + 1'b1 : wrBase;
  assign memWrData = strobe.wrHi ? wrByte[BYTE_W-1:NIB_W] : wrByte[NIB_W-1:0];

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int FLAG_W  = 4,
  parameter int DEPTH   = 8,
  parameter int NIB_W   = 4,
  parameter int MADDR_W = 6
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         opCode,
  input  logic [PC_W-1:0]    nextPc,
  input  logic [2*NIB_W-1:0] imm8,
  input  logic [MADDR_W-1:0] imm6,
  input  logic [PC_W/2-1:0]  extReg,
  input  logic               extFlag,
  input  logic [PC_W-1:0]    xReg,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [MADDR_W-1:0] memRdAddr,
  input  logic [NIB_W-1:0]   memRdData,
  output logic               pcLoad,
  output logic [PC_W-1:0]    pcOut,
  output logic               flagsLoad,
  output logic [FLAG_W-1:0]  flagsOut,
  output logic               memWe,
  output logic [PC_W-1:0]    memWrAddr,
  output logic [NIB_W-1:0]   memWrData,
  output logic               busy,
  output logic               ovfErr,
  output logic               unfErr
);

  seqStrobe_t strobe;
  logic       stackFull, stackEmpty;

  callret_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opCode     (opCode),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .strobe     (strobe),
    .busy       (busy)
  );

  callret_dp #(
    .PC_W    (PC_W),
    .FLAG_W  (FLAG_W),
    .DEPTH   (DEPTH),
    .NIB_W   (NIB_W),
    .MADDR_W (MADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .nextPc     (nextPc),
    .imm8       (imm8),
    .imm6       (imm6),
    .extReg     (extReg),
    .extFlag    (extFlag),
    .xReg       (xReg),
    .flagsIn    (flagsIn),
    .memRdData  (memRdData),
    .memRdAddr  (memRdAddr),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .pcLoad     (pcLoad),
    .pcOut      (pcOut),
    .flagsLoad  (flagsLoad),
    .flagsOut   (flagsOut),
    .memWe      (memWe),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .ovfErr     (ovfErr),
    .unfErr     (unfErr)
  );

endmodule

// File: rtl/callret_checker.sv
module callret_checker #(
  parameter int PC_W = 16
)(
  input logic            clk,
  input logic            rstN,
  input logic            pcLoad,
  input logic            flagsLoad,
  input logic            memWe,
  input logic [PC_W-1:0] memWrAddr,
  input logic            busy,
  input logic            ovfErr,
  input logic            unfErr
);

  // R8: second nibble follows the first at the next address
  a_r8_hi_follows_lo: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |=> (memWe && memWrAddr == $past(memWrAddr) + 1'b1));

  // R8: writes only happen inside the busy window
  a_r8_write_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R8: a write burst is two cycles long
  a_r8_two_writes: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |=> !memWe);

  // R9: a flag restore always comes with a PC load
  a_r9_flags_with_pc: assert property (@(posedge clk) disable iff (!rstN)
    flagsLoad |-> pcLoad);

  // R10: refused push loads nothing
  a_r10_no_load_on_ovf: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |-> (!pcLoad && !flagsLoad));

  // R11: refused pop loads nothing and writes nothing
  a_r11_no_effect_on_unf: assert property (@(posedge clk) disable iff (!rstN)
    unfErr |-> (!pcLoad && !flagsLoad && !memWe));

  // R12: op offered in the first write cycle is dropped
  a_r12_ignored_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (!pcLoad && !ovfErr && !unfErr));

  // R12: op offered in the last write cycle is dropped
  a_r12_ignored_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!pcLoad && !ovfErr && !unfErr));

  // R14: at most one error per cycle
  a_r14_single_error: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovfErr, unfErr}));

endmodule

bind callret_seq callret_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pcLoad    (pcLoad),
  .flagsLoad (flagsLoad),
  .memWe     (memWe),
  .memWrAddr (memWrAddr),
  .busy      (busy),
  .ovfErr    (ovfErr),
  .unfErr    (unfErr)
);

// File: tb/callret_seq_test.sv
module callret_seq_test;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  opCode;
  logic [15:0] nextPc;
  logic [7:0]  imm8;
  logic [5:0]  imm6;
  logic [7:0]  extReg;
  logic        extFlag;
  logic [15:0] xReg;
  logic [3:0]  flagsIn;
  logic [5:0]  memRdAddr;
  logic [3:0]  memRdData;
  logic        pcLoad;
  logic [15:0] pcOut;
  logic        flagsLoad;
  logic [3:0]  flagsOut;
  logic        memWe;
  logic [15:0] memWrAddr;
  logic [3:0]  memWrData;
  logic        busy;
  logic        ovfErr;
  logic        unfErr;

  int nChecks = 0;
  int nErrs   = 0;

  always #2 clk = ~clk;

  callret_seq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .nextPc(nextPc), .imm8(imm8),
    .imm6(imm6), .extReg(extReg), .extFlag(extFlag), .xReg(xReg),
    .flagsIn(flagsIn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .pcLoad(pcLoad), .pcOut(pcOut), .flagsLoad(flagsLoad), .flagsOut(flagsOut),
    .memWe(memWe), .memWrAddr(memWrAddr), .memWrData(memWrData), .busy(busy),
    .ovfErr(ovfErr), .unfErr(unfErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one operation for one edge, then sample after the edge
  task automatic issue(input logic [3:0] op);
    @(negedge clk);
    opCode = op;
    @(posedge clk);
    #1;
    opCode = 4'h0;
  endtask

  task automatic test_reset;
    rstN = 1'b0; opCode = 4'h0; nextPc = '0; imm8 = '0; imm6 = '0;
    extReg = '0; extFlag = 1'b0; xReg = '0; flagsIn = '0; memRdData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1 pcLoad", pcLoad, 0);
    chk("R1 busy", busy, 0);
    chk("R1 memWe", memWe, 0);
    chk("R1 errors", {ovfErr, unfErr}, 0);
    // undefined code does nothing (R14)
    issue(4'hC);
    chk("R14 undefined op", {pcLoad, ovfErr, unfErr, busy}, 0);
    // data return on empty stack (R11)
    issue(4'h7);
    chk("R11 unfErr", unfErr, 1);
    chk("R11 no load/write", {pcLoad, flagsLoad, memWe, busy}, 0);
  endtask

  task automatic test_abs_call;
    nextPc = 16'h1234; imm8 = 8'h50; flagsIn = 4'h3;
    issue(4'h1);
    chk("R2 pcLoad", pcLoad, 1);
    chk("R2 target", pcOut, 16'h0050);
    issue(4'h5);
    chk("R6 target", pcOut, 16'h1234);
    chk("R6 flagsLoad low", {pcLoad, flagsLoad}, 2'b10);
  endtask

  task automatic test_rel_call;
    nextPc = 16'h1000; imm8 = 8'h9C; extFlag = 1'b0;
    issue(4'h2);
    chk("R3 signed short", pcOut, 16'h0F9C);
    nextPc = 16'h0800; imm8 = 8'h32; extReg = 8'h32; extFlag = 1'b1;
    issue(4'h2);
    chk("R3 widened", pcOut, 16'h3A32);
    nextPc = 16'h0600; imm8 = 8'h00; extReg = 8'hFF;
    issue(4'h2);
    chk("R3 widened negative", pcOut, 16'h0500);
    extFlag = 1'b0;
    issue(4'h6);
    chk("R7 skip", pcOut, 16'h0601);
    issue(4'h6);
    chk("R7 skip", pcOut, 16'h0801);
    issue(4'h5);
    chk("R13 order", pcOut, 16'h1000);
  endtask

  task automatic test_mem_call_and_data_ret;
    imm6 = 6'h10;
    #1;
    chk("R4 read address", memRdAddr, 6'h10);
    memRdData = 4'h5; nextPc = 16'h2000;
    issue(4'h3);
    chk("R4 target", pcOut, 16'h2005);
    xReg = 16'h0040; imm8 = 8'hA7;
    issue(4'h7);
    chk("R8 load with low write", {pcLoad, flagsLoad, memWe, busy}, 4'b1011);
    chk("R8 return address", pcOut, 16'h2000);
    chk("R8 low addr", memWrAddr, 16'h0040);
    chk("R8 low data", memWrData, 4'h7);
    opCode = 4'h5;  // offered while busy
    @(posedge clk); #1;
    opCode = 4'h0;
    chk("R8 high write", {memWe, busy}, 2'b11);
    chk("R8 high addr", memWrAddr, 16'h0041);
    chk("R8 high data", memWrData, 4'hA);
    chk("R12 no load while busy", pcLoad, 0);
    @(posedge clk); #1;
    chk("R12 dropped op", {pcLoad, unfErr, busy, memWe}, 0);
    issue(4'h5);
    chk("R12 stack untouched", unfErr, 1);
  endtask

  task automatic test_interrupt;
    nextPc = 16'h3333; imm6 = 6'h3F; flagsIn = 4'hA;
    issue(4'h4);
    chk("R5 vector", pcOut, 16'h013F);
    flagsIn = 4'h5;
    issue(4'h8);
    chk("R9 pc", pcOut, 16'h3333);
    chk("R9 flagsLoad", flagsLoad, 1);
    chk("R9 flags", flagsOut, 4'hA);
  endtask

  task automatic test_overflow;
    for (int i = 0; i < DEPTH; i++) begin
      nextPc = 16'h0100 * i + 16'h7;
      imm8 = 8'(i);
      issue(4'h1);
      chk("R2 fill", pcOut, 32'(i));
    end
    nextPc = 16'hFFFF;
    issue(4'h2);
    chk("R10 ovfErr", ovfErr, 1);
    chk("R10 no load", pcLoad, 0);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      issue(4'h5);
      chk("R13 LIFO", pcOut, 16'h0100 * i + 16'h7);
    end
    issue(4'h8);
    chk("R11 empty after drain", {unfErr, pcLoad, flagsLoad}, 3'b100);
  endtask

  initial begin
    #(4 * 100000);
    nErrs++;
    nChecks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    test_reset();
    test_abs_call();
    test_rel_call();
    test_mem_call_and_data_ret();
    test_interrupt();
    test_overflow();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule